// File: doc/BRIEF.md
# Three-Wire Serial Time Record Port

This block is the slave side of a three-wire serial link to a calendar counter bank. The link has a chip enable, a serial clock and one data line that runs in both directions. The block samples all three lines with a synchroniser in a fast system clock and finds clock edges there, so the serial clock never clocks any logic. The data level at the first serial clock rise decides the direction of the frame. Every frame starts with an 8-bit control preamble. A 52-bit time record follows, least significant bit first.

For a read, the block takes a copy of the counter bank on the 8th falling serial edge and pulses a snapshot strobe. It then drives the copy out one bit per rising edge. For a write, it shifts in the 52 payload bits. It raises a hold to the counter bank from the first falling edge until chip enable drops, and it hands the record over with a one-cycle strobe only once the frame is complete. The pad itself is not part of the block: the three-state driver appears as a data output and an output enable.

Top module: `tw_serial_ctl`

## Requirements
- R1: While chip enable is high, the first rising serial clock edge chooses the frame type: data low starts a read and data high starts a write. The level seen at later edges does not change that choice.
- R2: Rising edges 1 to 8 of a frame are control bits and carry no payload. Payload moves on rising edges 9 to 60 inclusive. The internal edge count saturates at 60.
- R3: In a read, `snap_o` pulses for exactly one cycle after the 8th falling edge, and the record is copied at that moment. Any change on `rec_i` after that copy does not alter the bits shifted out in the same frame.
- R4: Read data leaves least significant bit first, one bit per rising edge from edge 9 onward. The record layout is: seconds [7:0], minutes [15:8], hours [23:16], week [27:24], day [35:28], month [43:36], year [51:44].
- R5: After the 60th rising edge of a read, `sdo_o` keeps its value however many further serial clocks arrive.
- R6: While chip enable is low, `sdo_oe_o` is 0 and serial clock and data activity starts no frame and causes no strobe. `sdo_oe_o` is 1 only during a read frame.
- R7: A write frame produces exactly one one-cycle `wr_stb_o` pulse once its 60th rising edge has been seen. A frame that ends with fewer than 60 rising edges produces no pulse.
- R8: In `wr_rec_o` the don't-care positions are forced to 0. These are record bits 15, 23, 22, 35, 34, 42 and 41. All other bits equal the received payload.
- R9: In a write, data on the 61st and later rising edges has no effect on `wr_rec_o`.
- R10: `hold_o` rises at the first falling serial edge of a write frame and stays high until chip enable is low. It is never high during a read.
- R11: `tst_clr_o` is 1 while chip enable is low and 0 while chip enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Chip enable, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data input from the pad |
| sdo_o | output | 1 | Serial data output to the pad |
| sdo_oe_o | output | 1 | Pad output enable |
| rec_i | input | 52 | Current counter record to snapshot for reads |
| snap_o | output | 1 | One-cycle pulse when the read snapshot is taken |
| wr_rec_o | output | 52 | Record received in the last complete write |
| wr_stb_o | output | 1 | One-cycle commit pulse for `wr_rec_o` |
| hold_o | output | 1 | Counter hold during a write frame |
| tst_clr_o | output | 1 | Clear request for the test bit while disabled |

## Verification
The hardest case to reach is a change of the live record between the snapshot and the end of a read. It only shows up if `rec_i` moves after the 8th falling edge and the frame then runs on to completion. The read task therefore changes `rec_i` a few system cycles after that falling edge and compares every shifted bit against the old value. The boundaries of the write frame are also awkward to hit from the ports: 59 edges must give no commit, and 70 edges must ignore the excess. The write task takes the edge count as an argument and drives inverted junk on every edge past the 60th.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int CTRL_BITS = 8;
  localparam int REC_BITS  = 52;
  localparam int FRAME_EDGES = CTRL_BITS + REC_BITS;
  localparam int EDGE_CW = $clog2(FRAME_EDGES + 1);

  // positions that are ignored on write
  localparam logic [REC_BITS-1:0] DC_MASK = 52'h060C00C08000;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_READ  = 2'd1,
    FR_WRITE = 2'd2
  } frame_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], raw_i[g]};
      end
      assign lvl_o[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tw_frame_ctl.sv
module tw_frame_ctl
  import tw_pkg::*;
#(
  parameter int CTRL_N  = CTRL_BITS,
  parameter int FRAME_N = FRAME_EDGES,
  parameter int CW      = EDGE_CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          sclk,
  input  logic          sdat,
  output frame_e        mode_o,
  output logic [CW-1:0] cnt_o,
  output logic          shift_rd_o,
  output logic          shift_wr_o,
  output logic          commit_o,
  output logic          snap_o,
  output logic          hold_o,
  output logic          oe_o,
  output logic          tclr_o
);
  localparam logic [CW-1:0] CTRL_C  = CW'(CTRL_N);
  localparam logic [CW-1:0] FRAME_C = CW'(FRAME_N);
  localparam logic [CW-1:0] LAST_C  = CW'(FRAME_N - 1);

  logic   sclk_d;
  logic   rise, fall;
  logic   in_payload;
  frame_e mode_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk;
  end

  assign rise = ce & sclk & ~sclk_d;
  assign fall = ce & ~sclk & sclk_d;

  // cnt_q holds the number of rises seen before this one
  assign in_payload = rise && (cnt_q >= CTRL_C) && (cnt_q < FRAME_C);
  assign shift_rd_o = in_payload && (mode_q == FR_READ);
  assign shift_wr_o = in_payload && (mode_q == FR_WRITE);
  assign commit_o   = shift_wr_o && (cnt_q == LAST_C);

  always_ff @(posedge clk) begin
    if (rst || !ce) begin
      cnt_q  <= '0;
      mode_q <= FR_IDLE;
      hold_o <= 1'b0;
    end else begin
      if (rise && cnt_q < FRAME_C) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == '0) mode_q <= sdat ? FR_WRITE : FR_READ;
      end
      if (fall && mode_q == FR_WRITE) hold_o <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_o <= 1'b0;
      oe_o   <= 1'b0;
      tclr_o <= 1'b1;
    end else begin
      snap_o <= fall && (mode_q == FR_READ) && (cnt_q == CTRL_C);
      oe_o   <= ce && (mode_q == FR_READ);
      tclr_o <= ~ce;
    end
  end

  assign mode_o = mode_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter
  import tw_pkg::*;
#(
  parameter int W = REC_BITS,
  parameter logic [W-1:0] IGN = DC_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] rec_i,
  input  logic         shift_rd_i,
  input  logic         shift_wr_i,
  input  logic         din_i,
  input  logic         commit_i,
  output logic         sdo_o,
  output logic [W-1:0] wr_rec_o,
  output logic         wr_stb_o
);
  logic [W-1:0] sreg;
  logic         pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg  <= '0;
      sdo_o <= 1'b0;
    end else if (load_i) begin
      sreg  <= rec_i;
      sdo_o <= 1'b0;
    end else if (shift_rd_i) begin
      sdo_o <= sreg[0];
      sreg  <= {1'b0, sreg[W-1:1]};
    end else if (shift_wr_i) begin
      sreg  <= {din_i, sreg[W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      wr_stb_o <= 1'b0;
      wr_rec_o <= '0;
    end else begin
      pend     <= commit_i;
      wr_stb_o <= pend;
      if (pend) wr_rec_o <= sreg & ~IGN;
    end
  end
endmodule

// File: rtl/tw_serial_ctl.sv
module tw_serial_ctl
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REC_W       = REC_BITS,
  parameter int CTRL_W      = CTRL_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_i,
  input  logic             sclk_i,
  input  logic             sdi_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  input  logic [REC_W-1:0] rec_i,
  output logic             snap_o,
  output logic [REC_W-1:0] wr_rec_o,
  output logic             wr_stb_o,
  output logic             hold_o,
  output logic             tst_clr_o
);
  localparam int FRAME_N = CTRL_W + REC_W;
  localparam int CW      = $clog2(FRAME_N + 1);

  logic [2:0]    lvl;
  frame_e        mode;
  logic [CW-1:0] edge_cnt;
  logic          shift_rd, shift_wr, commit;

  tw_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .raw_i({sdi_i, sclk_i, ce_i}),
    .lvl_o(lvl)
  );

  tw_frame_ctl #(.CTRL_N(CTRL_W), .FRAME_N(FRAME_N), .CW(CW)) u_ctl (
    .clk(clk), .rst(rst),
    .ce(lvl[0]), .sclk(lvl[1]), .sdat(lvl[2]),
    .mode_o(mode), .cnt_o(edge_cnt),
    .shift_rd_o(shift_rd), .shift_wr_o(shift_wr), .commit_o(commit),
    .snap_o(snap_o), .hold_o(hold_o), .oe_o(sdo_oe_o), .tclr_o(tst_clr_o)
  );

  tw_shifter #(.W(REC_W), .IGN(DC_MASK)) u_shift (
    .clk(clk), .rst(rst),
    .load_i(snap_o), .rec_i(rec_i),
    .shift_rd_i(shift_rd), .shift_wr_i(shift_wr),
    .din_i(lvl[2]), .commit_i(commit),
    .sdo_o(sdo_o), .wr_rec_o(wr_rec_o), .wr_stb_o(wr_stb_o)
  );
endmodule

// File: rtl/tw_serial_chk.sv
module tw_serial_chk
  import tw_pkg::*;
#(
  parameter int CW = EDGE_CW,
  parameter int FRAME_N = FRAME_EDGES
) (
  input logic          clk,
  input logic          rst,
  input logic          sdo_o,
  input logic          sdo_oe_o,
  input logic          snap_o,
  input logic          wr_stb_o,
  input logic          hold_o,
  input logic          tst_clr_o,
  input frame_e        mode,
  input logic [CW-1:0] edge_cnt
);
  assert_cnt_sat_R2: assert property (@(posedge clk) disable iff (rst)
    edge_cnt <= CW'(FRAME_N));

  assert_snap_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    snap_o |=> !snap_o);

  assert_sdo_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == FR_READ && edge_cnt == CW'(FRAME_N) && $past(edge_cnt) == CW'(FRAME_N))
      |-> $stable(sdo_o));

  assert_oe_off_R6: assert property (@(posedge clk) disable iff (rst)
    tst_clr_o |-> !sdo_oe_o);

  assert_stb_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o);

  assert_hold_clear_R10: assert property (@(posedge clk) disable iff (rst)
    tst_clr_o |-> !hold_o);

  assert_hold_not_read_R10: assert property (@(posedge clk) disable iff (rst)
    sdo_oe_o |-> !hold_o);
endmodule

bind tw_serial_ctl tw_serial_chk #(.CW(CW), .FRAME_N(FRAME_N)) u_chk (
  .clk(clk), .rst(rst), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .snap_o(snap_o), .wr_stb_o(wr_stb_o), .hold_o(hold_o),
  .tst_clr_o(tst_clr_o), .mode(mode), .edge_cnt(edge_cnt)
);

// File: tb/tb_tw_serial_ctl.sv
module tb_tw_serial_ctl;
  localparam int W = 52;
  localparam int HB = 8;
  localparam logic [W-1:0] IGN = 52'h060C00C08000;

  logic clk = 1'b0, rst = 1'b1;
  logic ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, oe, snap, stb, hold, tclr;
  logic [W-1:0] rec = '0, wrec;

  int checks = 0, fails = 0, cyc = 0;
  int snap_cnt = 0, stb_cnt = 0;
  logic [W-1:0] got;

  always #5 clk = ~clk;

  tw_serial_ctl dut (
    .clk(clk), .rst(rst), .ce_i(ce), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(oe), .rec_i(rec), .snap_o(snap),
    .wr_rec_o(wrec), .wr_stb_o(stb), .hold_o(hold), .tst_clr_o(tclr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && snap) snap_cnt <= snap_cnt + 1;
    if (!rst && stb)  stb_cnt  <= stb_cnt + 1;
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // read frame of n rising edges; optional record change after snapshot
  task automatic rd_frame(input int n, input bit alter, input logic [W-1:0] newrec,
                          output logic [W-1:0] data, output logic last60, output logic frz_ok);
    data = '0; last60 = 1'b0; frz_ok = 1'b1;
    ce = 1'b1; idle(HB);
    for (int i = 1; i <= n; i++) begin
      sdi = (i == 1) ? 1'b0 : 1'b1;
      sclk = 1'b1; idle(HB);
      if (i >= 9 && i <= 60) data[i-9] = sdo;
      if (i == 60) last60 = sdo;
      if (i > 60 && sdo !== last60) frz_ok = 1'b0;
      sclk = 1'b0; idle(HB);
      if (alter && i == 8) begin idle(4); rec = newrec; end
    end
    ce = 1'b0; sdi = 1'b0; idle(HB);
  endtask

  task automatic wr_frame(input int n, input logic [W-1:0] data,
                          output logic hold_mid, output logic oe_mid);
    hold_mid = 1'b0; oe_mid = 1'b0;
    ce = 1'b1; idle(HB);
    for (int i = 1; i <= n; i++) begin
      if (i == 1) sdi = 1'b1;
      else if (i <= 8) sdi = 1'b0;
      else if (i <= 60) sdi = data[i-9];
      else sdi = ~data[(i-61) % W];
      sclk = 1'b1; idle(HB);
      sclk = 1'b0; idle(HB);
      if (i == 2) begin hold_mid = hold; oe_mid = oe; end
    end
    ce = 1'b0; sdi = 1'b0; idle(HB);
  endtask

  task automatic t_reset();
    chk("R6 reset oe", W'(oe), W'(0));
    chk("R7 reset stb", W'(stb), W'(0));
    chk("R10 reset hold", W'(hold), W'(0));
    chk("R11 reset tclr", W'(tclr), W'(1));
  endtask

  task automatic t_read_basic();
    logic [W-1:0] d; logic l, f; int s0;
    rec = 52'hA_5C3B_7D19_E246; s0 = snap_cnt;
    rd_frame(60, 1'b0, '0, d, l, f);
    chk("R4 read order", d, 52'hA_5C3B_7D19_E246);
    chk("R1 read selected", W'(snap_cnt - s0), W'(1));
  endtask

  task automatic t_read_snapshot();
    logic [W-1:0] d; logic l, f; int s0;
    rec = 52'h1_2345_6789_ABCD; s0 = snap_cnt;
    rd_frame(60, 1'b1, 52'hF_0F0F_0F0F_0F0F, d, l, f);
    chk("R3 snapshot kept", d, 52'h1_2345_6789_ABCD);
    chk("R3 one snap pulse", W'(snap_cnt - s0), W'(1));
  endtask

  task automatic t_read_overrun();
    logic [W-1:0] d; logic l, f;
    rec = 52'h8_0000_0000_0001;
    rd_frame(66, 1'b0, '0, d, l, f);
    chk("R5 payload", d, 52'h8_0000_0000_0001);
    chk("R5 frozen after 60", W'(f), W'(1));
    chk("R2 last bit", W'(l), W'(1));
  endtask

  task automatic t_oe();
    ce = 1'b1; idle(HB);
    sdi = 1'b0; sclk = 1'b1; idle(HB);
    chk("R6 oe in read", W'(oe), W'(1));
    chk("R11 tclr with ce", W'(tclr), W'(0));
    sclk = 1'b0; idle(HB);
    ce = 1'b0; idle(HB);
    chk("R6 oe after ce low", W'(oe), W'(0));
  endtask

  task automatic t_write_full();
    logic h, o; int s0;
    s0 = stb_cnt;
    wr_frame(60, 52'hF_FFFF_FFFF_FFFF, h, o);
    chk("R7 one commit", W'(stb_cnt - s0), W'(1));
    chk("R8 mask", wrec, 52'hF_FFFF_FFFF_FFFF & ~IGN);
    chk("R10 hold during write", W'(h), W'(1));
    chk("R1 write no oe", W'(o), W'(0));
    chk("R10 hold after ce low", W'(hold), W'(0));
  endtask

  task automatic t_write_short();
    logic h, o; int s0; logic [W-1:0] prev;
    s0 = stb_cnt; prev = wrec;
    wr_frame(59, 52'h0_1111_2222_3333, h, o);
    chk("R7 short no commit", W'(stb_cnt - s0), W'(0));
    chk("R7 short rec unchanged", wrec, prev);
  endtask

  task automatic t_write_long();
    logic h, o; int s0;
    s0 = stb_cnt;
    wr_frame(70, 52'h3_9111_0422_1315, h, o);
    chk("R9 one commit", W'(stb_cnt - s0), W'(1));
    chk("R9 extra ignored", wrec, 52'h3_9111_0422_1315 & ~IGN);
  endtask

  task automatic t_ce_low_clocks();
    int s0, n0;
    s0 = stb_cnt; n0 = snap_cnt;
    for (int i = 0; i < 70; i++) begin
      sdi = i[0]; sclk = 1'b1; idle(HB); sclk = 1'b0; idle(HB);
    end
    chk("R6 no commit ce low", W'(stb_cnt - s0), W'(0));
    chk("R6 no snap ce low", W'(snap_cnt - n0), W'(0));
    chk("R6 oe low", W'(oe), W'(0));
  endtask

  initial begin
    idle(4); rst = 1'b0; idle(4);
    t_reset();
    t_read_basic();
    t_read_snapshot();
    t_read_overrun();
    t_oe();
    t_write_full();
    t_write_short();
    t_write_long();
    t_ce_low_clocks();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule